// File: doc/BRIEF.md
# Write protect boundary register with one-time lock

This block guards the write path of a small serial memory array. It holds the lowest address of a protected region, a flag that says whether protection is in force, and a lock bit that can be set once and never cleared. For every address that the surrounding write logic is about to program, the block answers with a single permit bit. One input selects a single-word check or a check of a whole four-word group. A second output tells the write-all logic whether the register is in its cleared state.

The block executes the protect-register instructions, which are the ones that arrive while the protect-enable pin is high. The instruction decoder upstream presents a one-cycle strobe, the 2-bit opcode, the 6-bit address field and the two pin states. Changing the register takes two instructions in sequence. First, an authorising instruction must be issued while the general write-enable latch and the write-enable pin are both set. Then exactly one modifying instruction can follow. A readback word carries the whole register state for the serial output shifter. Non-volatile cells are modelled as flops whose reset value is the erased state.

Top module: `wprot_guard`

## Requirements
- R1: After reset the boundary is 63, the flag is 1 (cleared), the lock is 0 and no authorisation is held, so the readback word is 0x1FC and `prot_cleared` is 1.
- R2: The readback word `rb_word` has the boundary in bits 8..3, the flag in bit 2, the lock in bit 1, and 0 in bit 0. It reflects a change in the cycle after the strobe edge that caused it.
- R3: The authorising instruction is a strobe with `pin_pe`=1, opcode 00 and address bits 5..4 = 11. It grants authorisation only when `pin_we`=1 and `wen_latch`=1 at that time. Otherwise it grants none.
- R4: A modifying instruction changes nothing unless three conditions hold at its strobe: authorisation is held, `pin_we`=1 and the lock is 0. The modifying instructions are opcode 01 (set boundary), opcode 11 (clear) and opcode 00 with address 000000 (lock), each with `pin_pe`=1.
- R5: Every strobe with `pin_pe`=1 other than a granted authorisation removes authorisation. This includes refused, read and unknown instructions. A strobe with `pin_pe`=0, opcode 00 and address bits 5..4 = 00 also removes it. Other strobes with `pin_pe`=0 leave it as it is.
- R6: Set boundary (opcode 01) stores the address field as the boundary and sets the flag to 0.
- R7: Clear (opcode 11) acts only with address 111111. It sets the boundary to 63 and the flag to 1.
- R8: Lock (opcode 00, address 000000) sets the lock bit. Nothing but reset clears it, and while it is set the boundary and flag never change.
- R9: For a single-word check (`chk_page`=0), `wr_permit` is 1 when the flag is 1 or `chk_addr` is below the boundary. Otherwise it is 0.
- R10: For a group check (`chk_page`=1), `wr_permit` is 1 when the flag is 1 or the highest address of the four-word group containing `chk_addr` (address bits 1..0 forced to 11) is below the boundary.
- R11: `prot_cleared` equals the flag. The read instruction (opcode 10, `pin_pe`=1) needs no write enable and changes neither the boundary, the flag nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the erased state |
| instr_valid | input | 1 | One-cycle strobe: a decoded instruction is to be executed |
| instr_op | input | 2 | Opcode bits of the instruction |
| instr_addr | input | 6 | Address field of the instruction |
| pin_pe | input | 1 | Protect-enable pin state |
| pin_we | input | 1 | Write-enable pin state |
| wen_latch | input | 1 | General write-enable latch of the memory |
| chk_addr | input | 6 | Address whose write permission is asked |
| chk_page | input | 1 | 1: check the whole four-word group, 0: single word |
| wr_permit | output | 1 | Write to the checked address or group is allowed |
| prot_cleared | output | 1 | Protect flag, 1 when the register is cleared |
| rb_word | output | 9 | Readback word for the serial shifter |

## Verification
Every register bit shows up in `rb_word` one cycle after the strobe that changed it. A wrong boundary, flag or lock therefore shows at the next sample. It shows again through `wr_permit` as soon as an address next to the boundary is checked. The authorisation bit is not visible directly. A fault in it shows only when a later modifying instruction is accepted or refused when it should not be, so each authorisation scenario ends with such an instruction and a readback.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int AW = 6;
  localparam int PGB = 2;
  localparam int RBW = AW + 3;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ,
    K_SETB,
    K_CLEAR,
    K_AUTH,
    K_LOCK,
    K_PR_OTHER,
    K_WDIS
  } kind_t;

  // highest address of the aligned group that holds a
  function automatic logic [AW-1:0] group_top(input logic [AW-1:0] a);
    return a | {{(AW-PGB){1'b0}}, {PGB{1'b1}}};
  endfunction

  function automatic logic permit_of(input logic flag, input logic [AW-1:0] bnd,
                                     input logic [AW-1:0] a, input logic page);
    logic [AW-1:0] top;
    top = page ? group_top(a) : a;
    return flag || (top < bnd);
  endfunction
endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
  import wprot_pkg::*;
(
  input  logic          valid,
  input  logic          pe,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  output kind_t         kind
);
  logic addr_ones, addr_zero;
  assign addr_ones = &addr;
  assign addr_zero = ~|addr;

  always_comb begin
    kind = K_NONE;
    if (valid) begin
      if (pe) begin
        unique case (op)
          2'b10: kind = K_READ;
          2'b01: kind = K_SETB;
          2'b11: kind = addr_ones ? K_CLEAR : K_PR_OTHER;
          default: begin
            if (addr[AW-1:AW-2] == 2'b11) kind = K_AUTH;
            else if (addr_zero)           kind = K_LOCK;
            else                          kind = K_PR_OTHER;
          end
        endcase
      end else if (op == 2'b00 && addr[AW-1:AW-2] == 2'b00) begin
        kind = K_WDIS;
      end
    end
  end
endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
  import wprot_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  kind_t         kind,
  input  logic [AW-1:0] addr,
  input  logic          pin_we,
  input  logic          wen_latch,
  output logic [AW-1:0] bound_q,
  output logic          flag_q,
  output logic          lock_q,
  output logic          auth_q
);
  logic is_pr_cmd, auth_grant, modify_ok;
  logic do_setb, do_clear, do_lock;

  assign is_pr_cmd  = (kind != K_NONE) && (kind != K_WDIS);
  assign auth_grant = (kind == K_AUTH) && pin_we && wen_latch;
  assign modify_ok  = auth_q && pin_we && !lock_q;
  assign do_setb    = modify_ok && (kind == K_SETB);
  assign do_clear   = modify_ok && (kind == K_CLEAR);
  assign do_lock    = modify_ok && (kind == K_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= {AW{1'b1}};
      flag_q  <= 1'b1;
      lock_q  <= 1'b0;
      auth_q  <= 1'b0;
    end else begin
      if (do_setb) begin
        bound_q <= addr;
        flag_q  <= 1'b0;
      end else if (do_clear) begin
        bound_q <= {AW{1'b1}};
        flag_q  <= 1'b1;
      end
      if (do_lock) lock_q <= 1'b1;
      if (is_pr_cmd)            auth_q <= auth_grant;
      else if (kind == K_WDIS)  auth_q <= 1'b0;
    end
  end

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(bound_q) && $stable(flag_q)));
  // R4
  no_auth_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auth_q |=> ($stable(bound_q) && $stable(flag_q) && $stable(lock_q)));
  // R5
  auth_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pr_cmd && kind != K_AUTH) |=> !auth_q);
  // R11
  read_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_READ) |=> ($stable(bound_q) && $stable(flag_q) && $stable(lock_q)));
endmodule

// File: rtl/wprot_permit.sv
module wprot_permit
  import wprot_pkg::*;
(
  input  logic          flag,
  input  logic [AW-1:0] bound,
  input  logic [AW-1:0] addr,
  input  logic          page,
  output logic          permit
);
  logic [AW-1:0] top;
  assign top    = page ? group_top(addr) : addr;
  assign permit = flag || (top < bound);

  // R10
  always_comb begin
    page_covers_single_chk: assert (!(page && permit) || flag || (addr < bound));
  end
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  input  logic [1:0]     instr_op,
  input  logic [AW-1:0]  instr_addr,
  input  logic           pin_pe,
  input  logic           pin_we,
  input  logic           wen_latch,
  input  logic [AW-1:0]  chk_addr,
  input  logic           chk_page,
  output logic           wr_permit,
  output logic           prot_cleared,
  output logic [RBW-1:0] rb_word
);
  kind_t         kind;
  logic [AW-1:0] bound_q;
  logic          flag_q, lock_q, auth_q;

  wprot_decode u_dec (
    .valid(instr_valid), .pe(pin_pe), .op(instr_op), .addr(instr_addr), .kind(kind)
  );

  wprot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .kind(kind), .addr(instr_addr),
    .pin_we(pin_we), .wen_latch(wen_latch),
    .bound_q(bound_q), .flag_q(flag_q), .lock_q(lock_q), .auth_q(auth_q)
  );

  wprot_permit u_perm (
    .flag(flag_q), .bound(bound_q), .addr(chk_addr), .page(chk_page), .permit(wr_permit)
  );

  assign prot_cleared = flag_q;
  assign rb_word      = {bound_q, flag_q, lock_q, 1'b0};

  // R9
  always_comb begin
    cleared_permits_chk: assert (!prot_cleared || wr_permit);
  end
  // R2
  always_comb begin
    rb_low_zero_chk: assert (rb_word[0] == 1'b0);
  end
endmodule

// File: tb/wprot_guard_bench.sv
module wprot_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [1:0] instr_op = 2'b00;
  logic [5:0] instr_addr = 6'd0;
  logic       pin_pe = 1'b0, pin_we = 1'b0, wen_latch = 1'b0;
  logic [5:0] chk_addr = 6'd0;
  logic       chk_page = 1'b0;
  logic       wr_permit, prot_cleared;
  logic [8:0] rb_word;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_guard u_wprot_guard (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_addr(instr_addr), .pin_pe(pin_pe), .pin_we(pin_we), .wen_latch(wen_latch),
    .chk_addr(chk_addr), .chk_page(chk_page), .wr_permit(wr_permit),
    .prot_cleared(prot_cleared), .rb_word(rb_word)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] rb(input logic [5:0] b, input logic f, input logic l);
    return {b, f, l, 1'b0};
  endfunction

  // permit restated: compare group's last word when page is asked
  function automatic logic ref_permit(input logic f, input logic [5:0] b,
                                      input logic [5:0] a, input logic pg);
    int last;
    last = pg ? (int'(a) / 4) * 4 + 3 : int'(a);
    return f || (last < int'(b));
  endfunction

  task automatic instr(input logic pe, input logic [1:0] op, input logic [5:0] a,
                       input logic we, input logic wl);
    @(negedge clk);
    pin_pe = pe; instr_op = op; instr_addr = a; pin_we = we; wen_latch = wl;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; pin_we = 1'b0; pin_pe = 1'b0;
  endtask

  task automatic grant();  instr(1'b1, 2'b00, 6'b110000, 1'b1, 1'b1); endtask

  task automatic probe(input string req, input logic [5:0] a, input logic pg,
                       input logic f, input logic [5:0] b);
    chk_addr = a; chk_page = pg;
    #1;
    check(req, {8'd0, wr_permit}, {8'd0, ref_permit(f, b, a, pg)});
  endtask

  task automatic t_reset();
    check("R1 readback", rb_word, 9'h1FC);
    check("R1 cleared", {8'd0, prot_cleared}, 9'd1);
    probe("R9 reset permit", 6'h3F, 1'b0, 1'b1, 6'h3F);
  endtask

  task automatic t_need_auth();
    instr(1'b1, 2'b01, 6'h10, 1'b1, 1'b1);
    check("R4 setb without auth", rb_word, 9'h1FC);
    instr(1'b1, 2'b00, 6'b110000, 1'b1, 1'b0);
    instr(1'b1, 2'b01, 6'h10, 1'b1, 1'b1);
    check("R3 no wen_latch", rb_word, 9'h1FC);
    instr(1'b1, 2'b00, 6'b111111, 1'b0, 1'b1);
    instr(1'b1, 2'b01, 6'h10, 1'b1, 1'b1);
    check("R3 no pin_we", rb_word, 9'h1FC);
  endtask

  task automatic t_setb_and_permit();
    grant();
    instr(1'b1, 2'b01, 6'h20, 1'b1, 1'b0);
    check("R6 setb readback", rb_word, rb(6'h20, 1'b0, 1'b0));
    check("R11 cleared low", {8'd0, prot_cleared}, 9'd0);
    probe("R9 below", 6'h1F, 1'b0, 1'b0, 6'h20);
    probe("R9 at boundary", 6'h20, 1'b0, 1'b0, 6'h20);
    probe("R9 top", 6'h3F, 1'b0, 1'b0, 6'h20);
    probe("R10 group below", 6'h1D, 1'b1, 1'b0, 6'h20);
    // authorisation used up: next setb refused
    instr(1'b1, 2'b01, 6'h05, 1'b1, 1'b0);
    check("R5 single use", rb_word, rb(6'h20, 1'b0, 1'b0));
  endtask

  task automatic t_group_edge();
    grant();
    instr(1'b1, 2'b01, 6'h1E, 1'b1, 1'b0);
    check("R6 setb 1E", rb_word, rb(6'h1E, 1'b0, 1'b0));
    probe("R9 single 1D", 6'h1D, 1'b0, 1'b0, 6'h1E);
    probe("R10 group 1C straddles", 6'h1C, 1'b1, 1'b0, 6'h1E);
    probe("R10 group 18", 6'h19, 1'b1, 1'b0, 6'h1E);
  endtask

  task automatic t_auth_clear();
    grant();
    instr(1'b0, 2'b00, 6'b000000, 1'b0, 1'b1);   // write-disable
    instr(1'b1, 2'b11, 6'h3F, 1'b1, 1'b0);
    check("R5 wdis drops auth", rb_word, rb(6'h1E, 1'b0, 1'b0));
    grant();
    instr(1'b0, 2'b01, 6'h02, 1'b1, 1'b1);       // ordinary write
    instr(1'b1, 2'b01, 6'h2A, 1'b1, 1'b0);
    check("R5 ordinary write keeps auth", rb_word, rb(6'h2A, 1'b0, 1'b0));
    grant();
    instr(1'b1, 2'b10, 6'h00, 1'b0, 1'b0);       // read, no write enable
    check("R11 read no change", rb_word, rb(6'h2A, 1'b0, 1'b0));
    instr(1'b1, 2'b11, 6'h3F, 1'b1, 1'b0);
    check("R5 read consumes auth", rb_word, rb(6'h2A, 1'b0, 1'b0));
  endtask

  task automatic t_clear();
    grant();
    instr(1'b1, 2'b11, 6'h3E, 1'b1, 1'b0);
    check("R7 wrong clear address", rb_word, rb(6'h2A, 1'b0, 1'b0));
    grant();
    instr(1'b1, 2'b11, 6'h3F, 1'b1, 1'b0);
    check("R7 clear", rb_word, 9'h1FC);
    check("R11 cleared flag", {8'd0, prot_cleared}, 9'd1);
    probe("R10 cleared group", 6'h3F, 1'b1, 1'b1, 6'h3F);
  endtask

  task automatic t_lock();
    grant();
    instr(1'b1, 2'b01, 6'h08, 1'b1, 1'b0);
    grant();
    instr(1'b1, 2'b00, 6'h00, 1'b0, 1'b0);
    check("R4 lock needs pin_we", rb_word, rb(6'h08, 1'b0, 1'b0));
    grant();
    instr(1'b1, 2'b00, 6'h00, 1'b1, 1'b0);
    check("R8 lock set", rb_word, rb(6'h08, 1'b0, 1'b1));
    grant();
    instr(1'b1, 2'b11, 6'h3F, 1'b1, 1'b0);
    check("R8 clear after lock", rb_word, rb(6'h08, 1'b0, 1'b1));
    grant();
    instr(1'b1, 2'b01, 6'h30, 1'b1, 1'b0);
    check("R8 setb after lock", rb_word, rb(6'h08, 1'b0, 1'b1));
    probe("R9 locked boundary", 6'h08, 1'b0, 1'b0, 6'h08);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_need_auth();
    t_setb_and_permit();
    t_group_edge();
    t_auth_clear();
    t_clear();
    t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule